// File: doc/BRIEF.md
# Memory Buffer Window Control

This block is the register slice that governs a host-programmable memory buffer window inside a storage controller. The host writes a 64-bit control word, either as two 32-bit halves or as one 64-bit access. That word carries a capability-registers enable, a window enable and a 4 KiB-aligned base address. From the control word the block publishes or withdraws the size and location capability words. It checks that the programmed window does not run past the top of the 64-bit address space, and it latches the base when the range is valid. Each cycle it tells the surrounding fabric, through a combinational flag, whether a probe address falls inside the live window.

A build parameter selects legacy operation. In that mode the capability words are published and the window is live from reset, anchored at a base address supplied by the BAR logic outside the block, and host writes change only the stored control word. A second parameter says whether the controller advertises buffer support at all. When it does not, writes to the low half of the control word are dropped. The buffer memory, BAR decoding and queue logic sit elsewhere.

Top module: `mbw_ctrl`

## Requirements
- R1: After reset in normal mode, the control word (offsets 0x50 and 0x54), the status word (0x58), the size word (0x3C) and the location word (0x38) all read 0, and no probe address hits.
- R2: A 32-bit write to 0x50 replaces only control bits 31:0. A 32-bit write to 0x54 replaces only bits 63:32, taken from wr_data[31:0]. A 64-bit write (wr_wide=1) to 0x50 replaces all 64 bits. A read at 0x50 returns bits 31:0 and a read at 0x54 returns bits 63:32.
- R3: A low-half write with control bit 0 set publishes the size word as sqs(bit0)=1, cqs(bit1)=0, lists(bit2)=1, read-data(bit3)=1, write-data(bit4)=1, unit(bits 11:8)=2, count(bits 31:12)=SIZE_MIB. The same write sets the location word bits 2:0 to BAR_IDX, with all other bits zero.
- R4: A low-half write with control bit 0 clear sets both the size word and the location word to zero and leaves the window off.
- R5: Every low-half write first turns the window off. The window turns on again only when control bits 0 and 1 are both set and the range is valid. The base is control bits 63:12 shifted left by 12, using the stored high half on a 32-bit write.
- R6: If base plus buffer bytes reaches or passes 2^64, status bit 0 at 0x58 is set, the window stays off and the earlier base is kept. The bit is sticky until reset.
- R7: probe_hit is 1 exactly when the window is on and base <= probe_addr < base + buffer bytes.
- R8: A write to 0x54 changes neither the window state, the base, nor the size and location words.
- R9: With CAP_BUF=0, writes to 0x50 are ignored: the stored low half, the capability words and the window keep their values.
- R10: With LEGACY=1, the size and location words are published and the window is on from reset at base bar_base_i. Control writes update only the stored control word.
- R11: The buffer byte count is the size count times 2^(12 + 4 x unit), which is SIZE_MIB x 2^20 for unit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bar_base_i | input | 64 | Base address of the BAR, used as the window base in legacy mode |
| wr_en | input | 1 | Register write strobe |
| wr_wide | input | 1 | 1 for a 64-bit write, 0 for a 32-bit write |
| wr_addr | input | 12 | Register byte offset of the write |
| wr_data | input | 64 | Write data, with the 32-bit data in bits 31:0 |
| rd_addr | input | 12 | Register byte offset of the read |
| rd_data | output | 32 | Combinational read data |
| probe_addr | input | 64 | Address checked against the window |
| probe_hit | output | 1 | Probe address lies inside the live window |

## Verification
On every cycle the assertions check four things. A hit never occurs while the window is off or below its base. The invalid-address flag never clears once set. A rejected range never leaves the window on. A high-half write never moves the window or the capability words. Other outcomes depend on the history of writes and are shown only by the bench's scenarios: the exact base that was latched, the merging of a 32-bit low write with an earlier high write, the upper window boundary at the byte count, the exact wrap point at 2^64, and the behaviour with buffer support off or in legacy mode.

// File: rtl/mbw_pkg.sv
package mbw_pkg;
  localparam logic [11:0] OFS_LOC     = 12'h038;
  localparam logic [11:0] OFS_SIZE    = 12'h03C;
  localparam logic [11:0] OFS_CTRL_LO = 12'h050;
  localparam logic [11:0] OFS_CTRL_HI = 12'h054;
  localparam logic [11:0] OFS_STAT    = 12'h058;
  localparam int          BASE_SHIFT  = 12;
  localparam int          BASE_FLD_W  = 64 - BASE_SHIFT;
  localparam logic [3:0]  UNIT_MIB    = 4'd2;

  typedef struct packed {
    logic [19:0] count;
    logic [3:0]  unit;
    logic [2:0]  rsv;
    logic        wr_data_ok;
    logic        rd_data_ok;
    logic        lists_ok;
    logic        cq_ok;
    logic        sq_ok;
  } size_word_t;

  // byte count of the buffer: count * 2^(12 + 4*unit)
  function automatic logic [64:0] buf_bytes(input logic [19:0] count,
                                            input logic [3:0] unit);
    logic [64:0] one_unit;
    one_unit = 65'd1 << (12 + 4 * int'(unit));
    return 65'(count) * one_unit;
  endfunction

  function automatic logic [31:0] make_size(input logic [19:0] mib);
    size_word_t w;
    w            = '0;
    w.count      = mib;
    w.unit       = UNIT_MIB;
    w.sq_ok      = 1'b1;
    w.cq_ok      = 1'b0;
    w.lists_ok   = 1'b1;
    w.rd_data_ok = 1'b1;
    w.wr_data_ok = 1'b1;
    return w;
  endfunction

  function automatic logic [31:0] make_loc(input logic [2:0] bar);
    return {29'd0, bar};
  endfunction

  // true when base + bytes reaches or passes 2^64
  function automatic logic range_wraps(input logic [63:0] base,
                                       input logic [64:0] bytes);
    logic [65:0] s;
    s = {2'b00, base} + {1'b0, bytes};
    return |s[65:64];
  endfunction

  function automatic logic in_window(input logic [63:0] addr,
                                     input logic [63:0] base,
                                     input logic [64:0] bytes);
    logic [65:0] top;
    top = {2'b00, base} + {1'b0, bytes};
    return (addr >= base) && ({2'b00, addr} < top);
  endfunction
endpackage

// File: rtl/mbw_ctrl_reg.sv
module mbw_ctrl_reg
  import mbw_pkg::*;
#(
  parameter bit CAP_BUF = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_wide,
  input  logic [11:0]           wr_addr,
  input  logic [63:0]           wr_data,
  output logic [63:0]           ctrl_q,
  output logic                  lo_wr,
  output logic                  hi_wr,
  output logic                  nxt_cre,
  output logic                  nxt_mse,
  output logic [BASE_FLD_W-1:0] nxt_base_fld
);
  logic [63:0] merged;

  assign lo_wr  = wr_en && (wr_addr == OFS_CTRL_LO) && CAP_BUF;
  assign hi_wr  = wr_en && (wr_addr == OFS_CTRL_HI);
  assign merged = wr_wide ? wr_data : {ctrl_q[63:32], wr_data[31:0]};

  assign nxt_cre      = merged[0];
  assign nxt_mse      = merged[1];
  assign nxt_base_fld = merged[63:BASE_SHIFT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (lo_wr) begin
      ctrl_q <= merged;
    end else if (hi_wr) begin
      ctrl_q[63:32] <= wr_data[31:0];
    end
  end
endmodule

// File: rtl/mbw_window.sv
module mbw_window
  import mbw_pkg::*;
#(
  parameter bit          LEGACY   = 1'b0,
  parameter int          SIZE_MIB = 4,
  parameter int          BAR_IDX  = 2,
  parameter logic [64:0] BYTES    = 65'd0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  eval,
  input  logic                  nxt_cre,
  input  logic                  nxt_mse,
  input  logic [BASE_FLD_W-1:0] nxt_base_fld,
  output logic                  regs_on,
  output logic                  win_en,
  output logic [63:0]           base_q,
  output logic                  addr_bad,
  output logic                  ovf_evt,
  output logic [31:0]           size_word,
  output logic [31:0]           loc_word
);
  localparam logic [19:0] MIB_F = SIZE_MIB[19:0];
  localparam logic [2:0]  BAR_F = BAR_IDX[2:0];

  logic [63:0] cand_base;
  logic        want_on;

  assign cand_base = {nxt_base_fld, {BASE_SHIFT{1'b0}}};
  assign want_on   = eval && nxt_cre && nxt_mse;
  assign ovf_evt   = want_on && range_wraps(cand_base, BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs_on  <= LEGACY;
      win_en   <= LEGACY;
      base_q   <= '0;
      addr_bad <= 1'b0;
    end else if (eval) begin
      regs_on <= nxt_cre;
      win_en  <= want_on && !ovf_evt;
      if (want_on && !ovf_evt) base_q <= cand_base;
      if (ovf_evt) addr_bad <= 1'b1;
    end
  end

  assign size_word = regs_on ? make_size(MIB_F) : 32'd0;
  assign loc_word  = regs_on ? make_loc(BAR_F) : 32'd0;
endmodule

// File: rtl/mbw_hit.sv
module mbw_hit
  import mbw_pkg::*;
#(
  parameter logic [64:0] BYTES = 65'd0
) (
  input  logic        win_en,
  input  logic [63:0] base,
  input  logic [63:0] probe_addr,
  output logic        hit
);
  assign hit = win_en && in_window(probe_addr, base, BYTES);
endmodule

// File: rtl/mbw_ctrl.sv
module mbw_ctrl
  import mbw_pkg::*;
#(
  parameter bit LEGACY   = 1'b0,
  parameter bit CAP_BUF  = 1'b1,
  parameter int SIZE_MIB = 4,
  parameter int BAR_IDX  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] bar_base_i,
  input  logic        wr_en,
  input  logic        wr_wide,
  input  logic [11:0] wr_addr,
  input  logic [63:0] wr_data,
  input  logic [11:0] rd_addr,
  output logic [31:0] rd_data,
  input  logic [63:0] probe_addr,
  output logic        probe_hit
);
  localparam logic [64:0] BYTES = buf_bytes(SIZE_MIB[19:0], UNIT_MIB);

  logic [63:0]           ctrl_q;
  logic                  lo_wr, hi_wr, lo_eval;
  logic                  nxt_cre, nxt_mse;
  logic [BASE_FLD_W-1:0] nxt_base_fld;
  logic                  regs_on, win_en, addr_bad, ovf_evt;
  logic [63:0]           base_q, eff_base;
  logic [31:0]           size_word, loc_word;

  mbw_ctrl_reg #(.CAP_BUF(CAP_BUF)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_wide(wr_wide),
    .wr_addr(wr_addr), .wr_data(wr_data), .ctrl_q(ctrl_q),
    .lo_wr(lo_wr), .hi_wr(hi_wr), .nxt_cre(nxt_cre), .nxt_mse(nxt_mse),
    .nxt_base_fld(nxt_base_fld)
  );

  // legacy mode: stored word only, window state frozen
  assign lo_eval = lo_wr && !LEGACY;

  mbw_window #(
    .LEGACY(LEGACY), .SIZE_MIB(SIZE_MIB), .BAR_IDX(BAR_IDX), .BYTES(BYTES)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .eval(lo_eval), .nxt_cre(nxt_cre),
    .nxt_mse(nxt_mse), .nxt_base_fld(nxt_base_fld), .regs_on(regs_on),
    .win_en(win_en), .base_q(base_q), .addr_bad(addr_bad),
    .ovf_evt(ovf_evt), .size_word(size_word), .loc_word(loc_word)
  );

  generate
    if (LEGACY) begin : g_legacy_base
      assign eff_base = bar_base_i;
    end else begin : g_prog_base
      assign eff_base = base_q;
    end
  endgenerate

  mbw_hit #(.BYTES(BYTES)) u_hit (
    .win_en(win_en), .base(eff_base), .probe_addr(probe_addr),
    .hit(probe_hit)
  );

  always_comb begin
    unique case (rd_addr)
      OFS_LOC:     rd_data = loc_word;
      OFS_SIZE:    rd_data = size_word;
      OFS_CTRL_LO: rd_data = ctrl_q[31:0];
      OFS_CTRL_HI: rd_data = ctrl_q[63:32];
      OFS_STAT:    rd_data = {31'd0, addr_bad};
      default:     rd_data = 32'd0;
    endcase
  end
endmodule

// File: rtl/mbw_chk.sv
module mbw_chk #(
  parameter bit LEGACY = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        lo_eval,
  input logic        hi_wr,
  input logic        nxt_cre,
  input logic        nxt_mse,
  input logic        ovf_evt,
  input logic        win_en,
  input logic        addr_bad,
  input logic        probe_hit,
  input logic [63:0] probe_addr,
  input logic [63:0] eff_base,
  input logic [31:0] size_word,
  input logic [31:0] loc_word
);
  a_r4_regs_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    lo_eval && !nxt_cre |=> size_word == 32'd0 && loc_word == 32'd0 && !win_en);

  a_r5_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
    lo_eval && !(nxt_cre && nxt_mse) |=> !win_en);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    addr_bad |=> addr_bad);

  a_r6_ovf_off: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> !win_en && addr_bad);

  a_r7_hit_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    probe_hit |-> win_en && probe_addr >= eff_base);

  a_r8_hi_stable: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr && !lo_eval |=> $stable(win_en) && $stable(size_word) && $stable(eff_base));

  generate
    if (LEGACY) begin : g_leg
      a_r10_always_on: assert property (@(posedge clk) disable iff (!rst_n)
        win_en && size_word != 32'd0);
    end
  endgenerate
endmodule

bind mbw_ctrl mbw_chk #(.LEGACY(LEGACY)) u_chk (
  .clk(clk), .rst_n(rst_n), .lo_eval(lo_eval), .hi_wr(hi_wr),
  .nxt_cre(nxt_cre), .nxt_mse(nxt_mse), .ovf_evt(ovf_evt),
  .win_en(win_en), .addr_bad(addr_bad), .probe_hit(probe_hit),
  .probe_addr(probe_addr), .eff_base(eff_base), .size_word(size_word),
  .loc_word(loc_word)
);

// File: tb/sim_mbw_ctrl.sv
`timescale 1ns/1ps
module sim_mbw_ctrl;
  localparam int          MIB   = 4;
  localparam int          BAR   = 2;
  localparam logic [64:0] NBYTE = 65'(MIB) * 65'd1048576;  // R11: 4 * 2^(12+8)
  localparam logic [63:0] LBASE = 64'h0000_0001_0000_0000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_wide = 1'b0;
  logic [11:0] wr_addr = '0, rd_addr = '0;
  logic [63:0] wr_data = '0, probe_addr = '0;
  logic [31:0] rd0, rd1, rd2;
  logic        hit0, hit1, hit2;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  // bench model of u0
  logic [63:0] m_ctrl = '0, m_base = '0;
  logic        m_en = 1'b0, m_cre = 1'b0, m_sts = 1'b0;

  always #2.5 clk = ~clk;

  mbw_ctrl #(.SIZE_MIB(MIB), .BAR_IDX(BAR)) u0 (
    .clk(clk), .rst_n(rst_n), .bar_base_i(LBASE), .wr_en(wr_en),
    .wr_wide(wr_wide), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd0), .probe_addr(probe_addr), .probe_hit(hit0));
  mbw_ctrl #(.CAP_BUF(1'b0), .SIZE_MIB(MIB), .BAR_IDX(BAR)) u1 (
    .clk(clk), .rst_n(rst_n), .bar_base_i(LBASE), .wr_en(wr_en),
    .wr_wide(wr_wide), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd1), .probe_addr(probe_addr), .probe_hit(hit1));
  mbw_ctrl #(.LEGACY(1'b1), .SIZE_MIB(MIB), .BAR_IDX(BAR)) u2 (
    .clk(clk), .rst_n(rst_n), .bar_base_i(LBASE), .wr_en(wr_en),
    .wr_wide(wr_wide), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd2), .probe_addr(probe_addr), .probe_hit(hit2));

  function automatic logic [31:0] exp_size(input logic on);
    return on ? ((32'(MIB) << 12) | (32'd2 << 8) | 32'h1D) : 32'd0;
  endfunction

  function automatic logic exp_hit(input logic [63:0] a);
    logic [65:0] lim;
    lim = {2'b00, m_base} + {1'b0, NBYTE};
    return m_en && a >= m_base && {2'b00, a} < lim;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d, input logic w);
    logic [63:0] nv;
    logic [63:0] b;
    logic [65:0] s;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_wide = w;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 12'h050) begin
      nv = w ? d : {m_ctrl[63:32], d[31:0]};
      m_ctrl = nv;
      m_en = 1'b0;
      m_cre = nv[0];
      if (nv[0] && nv[1]) begin
        b = {nv[63:12], 12'h000};
        s = {2'b00, b} + {1'b0, NBYTE};
        if (s[65:64] != 2'b00) m_sts = 1'b1;
        else begin m_base = b; m_en = 1'b1; end
      end
    end else if (a == 12'h054) begin
      m_ctrl[63:32] = d[31:0];
    end
  endtask

  task automatic rdr(input logic [11:0] a, output logic [31:0] v0,
                     output logic [31:0] v1, output logic [31:0] v2);
    rd_addr = a; #1;
    v0 = rd0; v1 = rd1; v2 = rd2;
  endtask

  task automatic probe(input logic [63:0] a);
    probe_addr = a; #1;
  endtask

  task automatic check_u0(input string tag);
    logic [31:0] a, b, c;
    rdr(12'h050, a, b, c); chk({tag, " R2 lo"}, 64'(a), 64'(m_ctrl[31:0]));
    rdr(12'h054, a, b, c); chk({tag, " R2 hi"}, 64'(a), 64'(m_ctrl[63:32]));
    rdr(12'h03C, a, b, c); chk({tag, " R3 size"}, 64'(a), 64'(exp_size(m_cre)));
    rdr(12'h038, a, b, c); chk({tag, " R4 loc"}, 64'(a), m_cre ? 64'(BAR) : 64'd0);
    rdr(12'h058, a, b, c); chk({tag, " R6 status"}, 64'(a), 64'(m_sts));
    probe(m_base);                    chk({tag, " R7 at base"}, 64'(hit0), 64'(exp_hit(probe_addr)));
    probe(m_base - 64'd1);            chk({tag, " R7 below"}, 64'(hit0), 64'(exp_hit(probe_addr)));
    probe(m_base + NBYTE[63:0] - 1);  chk({tag, " R11 last"}, 64'(hit0), 64'(exp_hit(probe_addr)));
    probe(m_base + NBYTE[63:0]);      chk({tag, " R11 end"}, 64'(hit0), 64'(exp_hit(probe_addr)));
    probe({$urandom, $urandom});      chk({tag, " R7 rand"}, 64'(hit0), 64'(exp_hit(probe_addr)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] a, b, c;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R10 legacy from reset
    check_u0("reset R1");
    probe(LBASE);                    chk("R10 legacy hit base", 64'(hit2), 64'd1);
    probe(LBASE + NBYTE[63:0]);      chk("R10 legacy end", 64'(hit2), 64'd0);
    rdr(12'h03C, a, b, c);           chk("R10 legacy size", 64'(c), 64'(exp_size(1'b1)));
    rdr(12'h038, a, b, c);           chk("R10 legacy loc", 64'(c), 64'(BAR));

    // R3/R5 32-bit enable at low base
    wr(12'h050, 64'hFFFF_FFFF_0001_0003, 1'b0);
    check_u0("R5 lo32");
    rdr(12'h050, a, b, c);           chk("R9 cap off lo", 64'(b), 64'd0);
    rdr(12'h03C, a, b, c);           chk("R9 cap off size", 64'(b), 64'd0);
    probe(64'h1_0000);               chk("R9 cap off hit", 64'(hit1), 64'd0);
    rdr(12'h050, a, b, c);           chk("R10 legacy stores", 64'(c), 64'h1_0003);
    probe(LBASE);                    chk("R10 legacy still on", 64'(hit2), 64'd1);

    // R8 high write alone leaves window
    wr(12'h054, 64'h0000_0000_0000_0005, 1'b0);
    check_u0("R8 hi");
    rdr(12'h054, a, b, c);           chk("R9 cap off hi stored", 64'(b), 64'd5);
    // low write uses stored high half
    wr(12'h050, 64'h0000_0000_0020_0003, 1'b0);
    check_u0("R5 merged");
    // R4 clear
    wr(12'h050, 64'h0000_0000_0000_0002, 1'b0);
    check_u0("R4 off");
    // bit0 only: published, window off
    wr(12'h050, 64'h0000_0000_0000_1001, 1'b1);
    check_u0("R5 cre only");
    // R2 wide write, last valid base
    wr(12'h050, 64'hFFFF_FFFF_FFBF_F003, 1'b1);
    check_u0("R2 wide top");
    // R6 exact wrap at 2^64
    wr(12'h050, 64'hFFFF_FFFF_FFC0_0003, 1'b1);
    check_u0("R6 wrap");
    wr(12'h050, 64'h0000_0000_0040_0003, 1'b1);
    check_u0("R6 sticky");

    // constrained random
    for (int i = 0; i < 60; i++) begin
      logic [63:0] d;
      int op;
      op = int'($urandom % 4);
      d = {$urandom, $urandom};
      if ($urandom % 4 != 0) d[1:0] = 2'b11;
      case (op)
        0: wr(12'h050, d, 1'b0);
        1: wr(12'h050, d, 1'b1);
        2: wr(12'h054, d, 1'b0);
        default: begin d[63:32] = 32'hFFFF_FFFF; wr(12'h050, d, 1'b1); end
      endcase
      check_u0("rand R7");
    end

    done = 1'b1;
    finish_run();
  end
endmodule